// File: doc/BRIEF.md
# Cascaded 8-bit function-select ALU

This block is an 8-bit arithmetic and logic unit made from two identical 4-bit slices. A 4-bit function select and a mode bit choose one of sixteen bitwise logic functions or one of sixteen arithmetic functions of two operands. In arithmetic mode every slice produces a ripple carry and also lookahead group signals, propagate and generate. The low slice's carry out drives the high slice's carry in through plain wiring, with no register between them. The chip-level propagate and generate combine the two slices with the usual lookahead formulas. An all-ones detector on each slice gives an equality flag, and the chip flag is the AND of the slice flags.

All data is active high. The carry input, carry output, propagate and generate are active low: a 1 on the carry input means no carry. The result, carry out, propagate, generate and equality flag are captured together in one output register on the rising clock edge. A synchronous reset clears that register. The slice width and the slice count are parameters, and the defaults give 4 and 2.

A common use closes the loop outside the block. The unit is set to add, the first operand is held at 1 and the result is fed back into the second operand. The unit then counts up by one every clock.

Top module: `alu8_cascade`

## Requirements
- R1: With logic_mode=1, the select codes give these results. 0000 gives ~A, 0001 gives ~(A|B), 0010 gives ~A&B, 0011 gives all zeros, 0100 gives ~(A&B), 0101 gives ~B, 0110 gives A^B, and 0111 gives A&~B. For A=8'hAA and B=8'hF0, code 0000 gives 8'h55 and code 0110 gives 8'h5A.
- R2: With logic_mode=1, the select codes give these results. 1000 gives ~A|B, 1001 gives ~(A^B), 1010 gives B, 1011 gives A&B, 1100 gives all ones, 1101 gives A|~B, 1110 gives A|B, and 1111 gives A. For A=8'hAA and B=8'hF0, code 1110 gives 8'hFA.
- R3: With logic_mode=0 and fsel=1001, {~carry_out_n, res} equals A + B + c. Here c is 1 when carry_in_n=0 and 0 when carry_in_n=1.
- R4: With logic_mode=0 and fsel=0110, {~carry_out_n, res} equals A + ~B + c. The result is therefore A minus B minus 1, plus the carry.
- R5: With logic_mode=0, these codes give the following results, plus c. 0000 gives A. 0011 gives all ones, so it becomes zero with c=1. 1100 gives A+A. 1111 gives A minus 1, so it becomes A with c=1.
- R6: The carry from the low nibble reaches the high nibble in the same cycle. For example, 8'h0F + 8'h01 gives 8'h10 on the first edge after the operands are applied.
- R7: With fsel=1001 and logic_mode=0, gen_n is low exactly when A + B with no carry in overflows 8 bits. prop_n is low exactly when every bit position has A or B set.
- R8: match is high exactly when all 8 registered result bits are 1. With fsel=0110, logic_mode=0 and carry_in_n=1, this means A equals B.
- R9: All outputs are registered and change on the rising edge after their inputs. When rst is high at an edge, res, carry_out_n, prop_n, gen_n and match all become 0.
- R10: With fsel=1001, logic_mode=0, carry_in_n=1, A=1 and B driven from res, res increments by one on every edge and wraps from 8'hFF to 8'h00. carry_out_n is low on the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| fsel | input | 4 | Function select code |
| logic_mode | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| carry_in_n | input | 1 | Carry into the low slice, active low |
| res | output | 8 | Registered result |
| carry_out_n | output | 1 | Registered carry from the high slice, active low |
| prop_n | output | 1 | Registered group propagate, active low |
| gen_n | output | 1 | Registered group generate, active low |
| match | output | 1 | Registered all-ones flag, AND of both slices |

## Verification
The bench targets the carry crossing between the slices: 8'h0F plus 1, and a counter running from 8'hF8 through the wrap. A design that registered the slice link would show the high nibble one clock late. A design with the wrong carry polarity would add one where none was asked for. Subtraction is tested with and without borrow to expose an inverted carry out. The equality flag is tested with equal and with off-by-one operands to catch a flag built from one slice only. Propagate and generate are tested with operands that propagate but do not generate, and with operands that generate. All sixteen logic codes are run on two operand pairs, so a swapped select bit changes at least one result.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned SEL_W = 4;

    typedef logic [SEL_W-1:0] fsel_t;

    // Select codes whose meaning other logic depends on
    localparam fsel_t SEL_NOT_A   = 4'b0000;
    localparam fsel_t SEL_SUB_DEC = 4'b0110;
    localparam fsel_t SEL_ADD     = 4'b1001;
    localparam fsel_t SEL_OR      = 4'b1110;

    // Per-slice status handed to the merge stage
    typedef struct packed {
        logic carry_n;   // carry out of the slice, active low
        logic prop_n;    // group propagate, active low
        logic gen_n;     // group generate, active low
        logic all_ones;  // every result bit of the slice is 1
    } slice_flags_t;

endpackage

// File: rtl/alu8_bit_term.sv
module alu8_bit_term
    import alu8_pkg::*;
(
    input  logic  opa_bit,
    input  logic  opb_bit,
    input  fsel_t fsel,
    output logic  gen_bit,
    output logic  prop_bit,
    output logic  half_bit
);

    // The two upper select bits choose which operand minterms generate.
    // The two lower select bits choose which B polarity is ORed into propagate.
    assign gen_bit  = (opa_bit & opb_bit & fsel[3]) | (opa_bit & ~opb_bit & fsel[2]);
    assign prop_bit = opa_bit | (opb_bit & fsel[0]) | (~opb_bit & fsel[1]);

    // The XOR of the two terms is the carry-free sum, and its inverse is the logic result
    assign half_bit = gen_bit ^ prop_bit;

endmodule

// File: rtl/alu8_slice.sv
module alu8_slice
    import alu8_pkg::*;
#(
    parameter int unsigned SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] opa,
    input  logic [SLICE_W-1:0] opb,
    input  fsel_t              fsel,
    input  logic               logic_mode,
    input  logic               carry_in_n,
    output logic [SLICE_W-1:0] res,
    output slice_flags_t       flags
);

    logic [SLICE_W-1:0] gen_v;
    logic [SLICE_W-1:0] prop_v;
    logic [SLICE_W-1:0] half_v;

    generate
        for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
            alu8_bit_term u_term (
                .opa_bit  (opa[i]),
                .opb_bit  (opb[i]),
                .fsel     (fsel),
                .gen_bit  (gen_v[i]),
                .prop_bit (prop_v[i]),
                .half_bit (half_v[i])
            );
        end
    endgenerate

    // Ripple carry inside the slice, computed as a running variable
    always_comb begin
        logic carry;
        carry = ~carry_in_n;
        for (int i = 0; i < SLICE_W; i++) begin
            res[i] = logic_mode ? ~half_v[i] : (half_v[i] ^ carry);
            carry  = gen_v[i] | (prop_v[i] & carry);
        end
        flags.carry_n = ~carry;
    end

    // Group lookahead terms, independent of the carry input
    always_comb begin
        logic gacc;
        gacc = 1'b0;
        for (int i = 0; i < SLICE_W; i++) begin
            gacc = gen_v[i] | (prop_v[i] & gacc);
        end
        flags.gen_n    = ~gacc;
        flags.prop_n   = ~(&prop_v);
        flags.all_ones = &res;
    end

endmodule

// File: rtl/alu8_flag_merge.sv
module alu8_flag_merge
    import alu8_pkg::*;
#(
    parameter int unsigned N_SLICES = 2
) (
    input  slice_flags_t flags [N_SLICES],
    output logic         prop_n,
    output logic         gen_n,
    output logic         all_ones
);

    // Lookahead combine from the low slice upward
    always_comb begin
        logic gacc;
        logic pacc;
        logic eacc;
        gacc = 1'b0;
        pacc = 1'b1;
        eacc = 1'b1;
        for (int i = 0; i < N_SLICES; i++) begin
            gacc = ~flags[i].gen_n | (~flags[i].prop_n & gacc);
            pacc = pacc & ~flags[i].prop_n;
            eacc = eacc & flags[i].all_ones;
        end
        gen_n    = ~gacc;
        prop_n   = ~pacc;
        all_ones = eacc;
    end

endmodule

// File: rtl/alu8_cascade.sv
module alu8_cascade
    import alu8_pkg::*;
#(
    parameter int unsigned SLICE_W  = 4,
    parameter int unsigned N_SLICES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SLICE_W*N_SLICES-1:0]   opa,
    input  logic [SLICE_W*N_SLICES-1:0]   opb,
    input  logic [3:0]                    fsel,
    input  logic                          logic_mode,
    input  logic                          carry_in_n,
    output logic [SLICE_W*N_SLICES-1:0]   res,
    output logic                          carry_out_n,
    output logic                          prop_n,
    output logic                          gen_n,
    output logic                          match
);

    localparam int unsigned DATA_W = SLICE_W * N_SLICES;

    logic [DATA_W-1:0] res_comb;
    logic              link_n [N_SLICES+1];
    slice_flags_t      slice_flags [N_SLICES];
    logic              prop_comb;
    logic              gen_comb;
    logic              ones_comb;

    assign link_n[0] = carry_in_n;

    // Slices in a chain; the link between them is a plain wire
    generate
        for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
            alu8_slice #(
                .SLICE_W (SLICE_W)
            ) u_slice (
                .opa        (opa[s*SLICE_W +: SLICE_W]),
                .opb        (opb[s*SLICE_W +: SLICE_W]),
                .fsel       (fsel),
                .logic_mode (logic_mode),
                .carry_in_n (link_n[s]),
                .res        (res_comb[s*SLICE_W +: SLICE_W]),
                .flags      (slice_flags[s])
            );
            assign link_n[s+1] = slice_flags[s].carry_n;
        end
    endgenerate

    alu8_flag_merge #(
        .N_SLICES (N_SLICES)
    ) u_merge (
        .flags    (slice_flags),
        .prop_n   (prop_comb),
        .gen_n    (gen_comb),
        .all_ones (ones_comb)
    );

    // One output register for all results
    always_ff @(posedge clk) begin
        if (rst) begin
            res         <= '0;
            carry_out_n <= 1'b0;
            prop_n      <= 1'b0;
            gen_n       <= 1'b0;
            match       <= 1'b0;
        end else begin
            res         <= res_comb;
            carry_out_n <= link_n[N_SLICES];
            prop_n      <= prop_comb;
            gen_n       <= gen_comb;
            match       <= ones_comb;
        end
    end

endmodule

// File: rtl/alu8_cascade_chk.sv
module alu8_cascade_chk
    import alu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [3:0]   fsel,
    input logic         logic_mode,
    input logic         carry_in_n,
    input logic [W-1:0] res,
    input logic         carry_out_n,
    input logic         prop_n,
    input logic         gen_n,
    input logic         match
);

    AST_LOGIC_NOT_A: assert property (@(posedge clk) disable iff (rst)
        (logic_mode && fsel == SEL_NOT_A) |=> res == ~$past(opa)); // R1

    AST_LOGIC_OR: assert property (@(posedge clk) disable iff (rst)
        (logic_mode && fsel == SEL_OR) |=> res == ($past(opa) | $past(opb))); // R2

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (!logic_mode && fsel == SEL_ADD) |=>
        {~carry_out_n, res} == ({1'b0, $past(opa)} + {1'b0, $past(opb)}
                                + {{W{1'b0}}, ~$past(carry_in_n)})); // R3

    AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst)
        (!logic_mode && fsel == SEL_SUB_DEC) |=>
        {~carry_out_n, res} == ({1'b0, $past(opa)} + {1'b0, ~$past(opb)}
                                + {{W{1'b0}}, ~$past(carry_in_n)})); // R4

    AST_MATCH_EQUAL: assert property (@(posedge clk) disable iff (rst)
        (!logic_mode && fsel == SEL_SUB_DEC && carry_in_n) |=>
        match == ($past(opa) == $past(opb))); // R8

    AST_MATCH_ONES: assert property (@(posedge clk) disable iff (rst)
        match == (&res)); // R8

endmodule

bind alu8_cascade alu8_cascade_chk #(.W(DATA_W)) u_chk (.*);

// File: tb/test_alu8_cascade.sv
`timescale 1ns/1ps
module test_alu8_cascade;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic [3:0] fsel = '0;
    logic       logic_mode = 1'b0;
    logic       carry_in_n = 1'b1;
    logic [7:0] res;
    logic       carry_out_n;
    logic       prop_n;
    logic       gen_n;
    logic       match;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alu8_cascade i_alu8_cascade (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .fsel(fsel),
        .logic_mode(logic_mode), .carry_in_n(carry_in_n), .res(res),
        .carry_out_n(carry_out_n), .prop_n(prop_n), .gen_n(gen_n), .match(match)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_logic(input logic [3:0] s, input logic [7:0] a, input logic [7:0] b);
        case (s)
            4'b0000: return ~a;
            4'b0001: return ~(a | b);
            4'b0010: return ~a & b;
            4'b0011: return 8'h00;
            4'b0100: return ~(a & b);
            4'b0101: return ~b;
            4'b0110: return a ^ b;
            4'b0111: return a & ~b;
            4'b1000: return ~a | b;
            4'b1001: return ~(a ^ b);
            4'b1010: return b;
            4'b1011: return a & b;
            4'b1100: return 8'hFF;
            4'b1101: return a | ~b;
            4'b1110: return a | b;
            default: return a;
        endcase
    endfunction

    // Drive at a falling edge; results are registered at the next rising edge
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [3:0] s,
                         input logic m, input logic cn);
        @(negedge clk);
        opa = a; opb = b; fsel = s; logic_mode = m; carry_in_n = cn;
        @(negedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "reset res", {8'h00, res}, 16'h0000);
        chk("R9", "reset flags", {12'h000, carry_out_n, prop_n, gen_n, match}, 16'h0000);
        rst = 1'b0;
    endtask

    task automatic test_logic_low();
        for (int v = 0; v < 2; v++) begin
            for (int s = 0; s < 8; s++) begin
                logic [7:0] a = (v == 0) ? 8'hAA : 8'h3C;
                logic [7:0] b = (v == 0) ? 8'hF0 : 8'h96;
                apply(a, b, s[3:0], 1'b1, 1'b1);
                chk("R1", $sformatf("logic code %0d", s), {8'h00, res}, {8'h00, exp_logic(s[3:0], a, b)});
            end
        end
        apply(8'hAA, 8'hF0, 4'b0000, 1'b1, 1'b0);
        chk("R1", "not A fixed vector", {8'h00, res}, 16'h0055);
    endtask

    task automatic test_logic_high();
        for (int v = 0; v < 2; v++) begin
            for (int s = 8; s < 16; s++) begin
                logic [7:0] a = (v == 0) ? 8'hAA : 8'h3C;
                logic [7:0] b = (v == 0) ? 8'hF0 : 8'h96;
                apply(a, b, s[3:0], 1'b1, 1'b0);
                chk("R2", $sformatf("logic code %0d", s), {8'h00, res}, {8'h00, exp_logic(s[3:0], a, b)});
            end
        end
        apply(8'hAA, 8'hF0, 4'b1110, 1'b1, 1'b1);
        chk("R2", "or fixed vector", {8'h00, res}, 16'h00FA);
    endtask

    task automatic test_add();
        apply(8'hFF, 8'h01, 4'b1001, 1'b0, 1'b1);
        chk("R3", "FF+01 sum", {8'h00, res}, 16'h0000);
        chk("R3", "FF+01 carry_n", {15'h0, carry_out_n}, 16'h0000);
        apply(8'h80, 8'h80, 4'b1001, 1'b0, 1'b0);
        chk("R3", "80+80+c", {7'h00, ~carry_out_n, res}, 16'h0101);
        apply(8'h12, 8'h34, 4'b1001, 1'b0, 1'b0);
        chk("R3", "12+34+c", {7'h00, ~carry_out_n, res}, 16'h0047);
    endtask

    task automatic test_sub();
        apply(8'h50, 8'h20, 4'b0110, 1'b0, 1'b1);
        chk("R4", "50-20-1", {7'h00, ~carry_out_n, res}, 16'h012F);
        apply(8'h20, 8'h50, 4'b0110, 1'b0, 1'b0);
        chk("R4", "20-50 with c", {7'h00, ~carry_out_n, res}, 16'h00D0);
    endtask

    task automatic test_other_arith();
        apply(8'h7F, 8'h00, 4'b0000, 1'b0, 1'b0);
        chk("R5", "A plus c", {8'h00, res}, 16'h0080);
        apply(8'h00, 8'h33, 4'b1111, 1'b0, 1'b1);
        chk("R5", "A minus 1", {8'h00, res}, 16'h00FF);
        apply(8'h41, 8'h00, 4'b1100, 1'b0, 1'b1);
        chk("R5", "A plus A", {8'h00, res}, 16'h0082);
        apply(8'h5C, 8'h11, 4'b0011, 1'b0, 1'b0);
        chk("R5", "minus one plus c", {8'h00, res}, 16'h0000);
    endtask

    task automatic test_no_lag();
        apply(8'h0F, 8'h01, 4'b1001, 1'b0, 1'b1);
        chk("R6", "nibble carry same edge", {8'h00, res}, 16'h0010);
    endtask

    task automatic test_lookahead();
        apply(8'hF0, 8'h0F, 4'b1001, 1'b0, 1'b1);
        chk("R7", "propagate only", {14'h0, prop_n, gen_n}, 16'h0001);
        apply(8'h80, 8'h80, 4'b1001, 1'b0, 1'b1);
        chk("R7", "generate", {15'h0, gen_n}, 16'h0000);
        apply(8'h01, 8'h02, 4'b1001, 1'b0, 1'b0);
        chk("R7", "neither", {14'h0, prop_n, gen_n}, 16'h0003);
    endtask

    task automatic test_match();
        apply(8'h5A, 8'h5A, 4'b0110, 1'b0, 1'b1);
        chk("R8", "equal operands", {15'h0, match}, 16'h0001);
        apply(8'h5A, 8'h5B, 4'b0110, 1'b0, 1'b1);
        chk("R8", "off by one", {15'h0, match}, 16'h0000);
        apply(8'h5A, 8'h4A, 4'b0110, 1'b0, 1'b1);
        chk("R8", "high nibble differs", {15'h0, match}, 16'h0000);
        apply(8'h12, 8'h34, 4'b1100, 1'b1, 1'b1);
        chk("R8", "logic all ones", {15'h0, match}, 16'h0001);
    endtask

    task automatic test_timing();
        apply(8'h11, 8'h22, 4'b1001, 1'b0, 1'b1);
        @(negedge clk);
        opa = 8'h40;
        chk("R9", "holds before edge", {8'h00, res}, 16'h0033);
        @(negedge clk);
        chk("R9", "updates after edge", {8'h00, res}, 16'h0062);
        rst = 1'b1;
        @(negedge clk);
        chk("R9", "sync reset mid run", {8'h00, res}, 16'h0000);
        rst = 1'b0;
    endtask

    task automatic test_counter();
        logic [7:0] exp_cnt;
        apply(8'h00, 8'hF8, 4'b1010, 1'b1, 1'b1);
        chk("R10", "preload", {8'h00, res}, 16'h00F8);
        exp_cnt = 8'hF8;
        opa = 8'h01; fsel = 4'b1001; logic_mode = 1'b0; carry_in_n = 1'b1;
        opb = res;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R10", $sformatf("count step %0d carry_n", k), {15'h0, carry_out_n},
                {15'h0, (exp_cnt == 8'hFF) ? 1'b0 : 1'b1});
            exp_cnt = exp_cnt + 8'h01;
            chk("R10", $sformatf("count step %0d", k), {8'h00, res}, {8'h00, exp_cnt});
            opb = res;
        end
    endtask

    initial begin
        test_reset();
        test_logic_low();
        test_logic_high();
        test_add();
        test_sub();
        test_other_arith();
        test_no_lag();
        test_lookahead();
        test_match();
        test_timing();
        test_counter();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule